// File: doc/BRIEF.md
# Interrupt Flag and Enable Unit

This unit is the interrupt collection point of a byte-wide parallel peripheral. It keeps one pending flag per interrupt source and one enable bit per source, and raises a single level interrupt output whenever any source is both pending and enabled. Three sources are event-driven: the two timers and the shift register each deliver a one-cycle set pulse, and each of those flags is cleared either by software writing a one to it or by a clear strobe that the neighbouring logic produces when software reads that source's data register. The remaining four sources are external level inputs whose flags simply follow the input, one cycle later.

Software reaches the unit through a simple byte bus. Offset 13 is the flag register: a read returns the seven flags plus a computed summary in bit 7, and a write clears the flags written as one. Offset 14 is the enable register: a write uses bit 7 to choose between setting and clearing the enables selected by the ones in bits 6..0, and a read returns the enables with bit 7 forced high.

Top module: `ife_unit`

## Requirements
- R1: After reset every flag and every enable is zero, so a flag read returns 0x00, an enable read returns 0x80 and the interrupt output is low.
- R2: The interrupt output is high exactly when at least one source has both its flag and its enable bit set.
- R3: A write to offset 13 clears each event flag whose data bit is 1; bits written as 0 leave their flags unchanged.
- R4: A write to offset 14 with data bit 7 equal to 1 sets every enable whose data bit (6..0) is 1 and leaves the rest.
- R5: A write to offset 14 with data bit 7 equal to 0 clears every enable whose data bit (6..0) is 1 and leaves the rest.
- R6: A read at offset 14 returns the seven enables in bits 6..0 and 1 in bit 7.
- R7: A read at offset 13 returns the seven flags in bits 6..0 and, in bit 7, 1 when any flag is both set and enabled.
- R8: The flags at bits 0, 1, 3 and 4 follow external level inputs 0, 1, 2 and 3 respectively, one clock later; a write-one-to-clear does not override a high level.
- R9: A one-cycle set pulse from timer 1, timer 2 or the shift register sets flag bit 6, 5 or 2 respectively on the next clock.
- R10: The shift-register read strobe clears flag bit 2, the timer 1 low-counter read strobe clears bit 6 and the timer 2 low-counter read strobe clears bit 5.
- R11: When a set pulse and a clear (strobe or write-one-to-clear) hit the same flag in the same cycle, the flag ends up set.
- R12: Writes to any offset other than 13 and 14 change no flag or enable, and the read data is 0x00 unless a read strobe addresses offset 13 or 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the addressed register |
| t1_expire | input | 1 | Timer 1 event pulse |
| t2_expire | input | 1 | Timer 2 event pulse |
| sr_done | input | 1 | Shift register event pulse |
| t1_lo_read | input | 1 | Timer 1 low counter was read, clears its flag |
| t2_lo_read | input | 1 | Timer 2 low counter was read, clears its flag |
| sr_read | input | 1 | Shift register data was read, clears its flag |
| ext_lvl | input | 4 | External interrupt levels |
| irq | output | 1 | Interrupt request, high while any enabled flag is pending |

## Verification
The two functions that collide are a source's set pulse and a clear of the same flag, either the read strobe from the neighbouring register or a software write-one-to-clear. The bench drives the timer 1 pulse together with its low-counter read strobe, and the shift-register pulse together with a flag write that has bit 2 set, in the same clock. It judges the outcome by reading the flag register on the following cycle and expecting the flag still set, while other flags cleared by the same write are gone.

// File: rtl/ife_pkg.sv
package ife_pkg;

  localparam int SRC_W  = 7;
  localparam int DATA_W = SRC_W + 1;

  typedef logic [SRC_W-1:0]  src_vec_t;
  typedef logic [DATA_W-1:0] bus_byte_t;

  // Enable update: top bit of the write chooses set or clear of the selected ones
  function automatic src_vec_t en_next(input src_vec_t cur, input bus_byte_t wd);
    src_vec_t sel;
    sel = wd[SRC_W-1:0];
    if (wd[DATA_W-1]) return cur | sel;
    else              return cur & ~sel;
  endfunction

  // Number of mask bits below position pos: index of a level input for that bit
  function automatic int count_below(input src_vec_t mask, input int pos);
    int n;
    n = 0;
    for (int k = 0; k < SRC_W; k++)
      if (k < pos && mask[k]) n++;
    return n;
  endfunction

  // Flag register view: summary bit over pending-and-enabled
  function automatic bus_byte_t flag_view(input src_vec_t flags, input src_vec_t en);
    return {|(flags & en), flags};
  endfunction

  // Enable register view: top bit reads as one
  function automatic bus_byte_t en_view(input src_vec_t en);
    return {1'b1, en};
  endfunction

endpackage

// File: rtl/ife_decode.sv
module ife_decode #(
  parameter int ADDR_W   = 4,
  parameter int FLAG_OFS = 13,
  parameter int EN_OFS   = 14
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic              flag_wr,
  output logic              en_wr,
  output logic              flag_rd,
  output logic              en_rd
);
  localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_OFS);
  localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(EN_OFS);

  logic hit_flag, hit_en;

  assign hit_flag = (addr == FLAG_A);
  assign hit_en   = (addr == EN_A);
  assign flag_wr  = wr & hit_flag;
  assign en_wr    = wr & hit_en;
  assign flag_rd  = rd & hit_flag;
  assign en_rd    = rd & hit_en;
endmodule

// File: rtl/ife_flag_cell.sv
module ife_flag_cell #(
  parameter bit LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_p,
  input  logic clr_p,
  input  logic lvl,
  output logic q
);
  logic d;

  // Event flag: set dominates clear; level flag: follows its input
  assign d = LEVEL ? lvl : (set_p | (q & ~clr_p));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d;
  end
endmodule

// File: rtl/ife_enable_reg.sv
module ife_enable_reg
  import ife_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr,
  input  bus_byte_t wdata,
  output src_vec_t  en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  en <= '0;
    else if (wr) en <= en_next(en, wdata);
  end
endmodule

// File: rtl/ife_unit.sv
module ife_unit
  import ife_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int FLAG_OFS = 13,
  parameter int EN_OFS   = 14,
  parameter int T1_BIT   = 6,
  parameter int T2_BIT   = 5,
  parameter int SR_BIT   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              t1_expire,
  input  logic              t2_expire,
  input  logic              sr_done,
  input  logic              t1_lo_read,
  input  logic              t2_lo_read,
  input  logic              sr_read,
  input  logic [3:0]        ext_lvl,
  output logic              irq
);
  localparam src_vec_t EVT_MASK = src_vec_t'((1 << T1_BIT) | (1 << T2_BIT) | (1 << SR_BIT));
  localparam src_vec_t LVL_MASK = ~EVT_MASK;

  logic     flag_wr, en_wr, flag_rd, en_rd;
  src_vec_t evt_set, strobe_clr, w1c_clr, flags_q, en_q, pend;

  ife_decode #(.ADDR_W(ADDR_W), .FLAG_OFS(FLAG_OFS), .EN_OFS(EN_OFS)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .flag_wr(flag_wr), .en_wr(en_wr), .flag_rd(flag_rd), .en_rd(en_rd)
  );

  always_comb begin
    evt_set = '0;
    evt_set[T1_BIT] = t1_expire;
    evt_set[T2_BIT] = t2_expire;
    evt_set[SR_BIT] = sr_done;
    strobe_clr = '0;
    strobe_clr[T1_BIT] = t1_lo_read;
    strobe_clr[T2_BIT] = t2_lo_read;
    strobe_clr[SR_BIT] = sr_read;
  end

  assign w1c_clr = flag_wr ? bus_wdata[SRC_W-1:0] : '0;

  for (genvar i = 0; i < SRC_W; i++) begin : g_flag
    if (LVL_MASK[i]) begin : g_lvl
      localparam int K = count_below(LVL_MASK, i);
      ife_flag_cell #(.LEVEL(1'b1)) u_cell (
        .clk(clk), .rst_n(rst_n), .set_p(1'b0), .clr_p(1'b0),
        .lvl(ext_lvl[K]), .q(flags_q[i])
      );
    end else begin : g_evt
      ife_flag_cell #(.LEVEL(1'b0)) u_cell (
        .clk(clk), .rst_n(rst_n), .set_p(evt_set[i]),
        .clr_p(strobe_clr[i] | w1c_clr[i]), .lvl(1'b0), .q(flags_q[i])
      );
    end
  end

  ife_enable_reg u_en (
    .clk(clk), .rst_n(rst_n), .wr(en_wr), .wdata(bus_wdata), .en(en_q)
  );

  assign pend = flags_q & en_q;
  assign irq  = |pend;

  always_comb begin
    bus_rdata = '0;
    if (flag_rd)    bus_rdata = flag_view(flags_q, en_q);
    else if (en_rd) bus_rdata = en_view(en_q);
  end
endmodule

// File: rtl/ife_unit_chk.sv
module ife_unit_chk #(
  parameter int ADDR_W   = 4,
  parameter int FLAG_OFS = 13,
  parameter int EN_OFS   = 14,
  parameter int T1_BIT   = 6,
  parameter int SR_BIT   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              t1_expire,
  input logic              sr_done,
  input logic              sr_read,
  input logic [3:0]        ext_lvl,
  input logic [6:0]        flags_q,
  input logic [6:0]        en_q,
  input logic              irq
);
  localparam logic [ADDR_W-1:0] FA = ADDR_W'(FLAG_OFS);
  localparam logic [ADDR_W-1:0] EA = ADDR_W'(EN_OFS);

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq); // R2

  AST_SUMMARY_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == FA) |-> (bus_rdata[7] == irq)); // R7

  AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == EA && bus_wdata[7]) |=> ((en_q & $past(bus_wdata[6:0])) == $past(bus_wdata[6:0]))); // R4

  AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == EA && !bus_wdata[7]) |=> ((en_q & $past(bus_wdata[6:0])) == '0)); // R5

  AST_EN_READ_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == EA) |-> bus_rdata[7]); // R6

  AST_W1C_SR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == FA && bus_wdata[SR_BIT] && !sr_done) |=> !flags_q[SR_BIT]); // R3

  AST_STROBE_SR: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_read && !sr_done) |=> !flags_q[SR_BIT]); // R10

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    t1_expire |=> flags_q[T1_BIT]); // R11

  AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (flags_q[0] == $past(ext_lvl[0]))); // R8

  AST_QUIET_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd || (bus_addr != FA && bus_addr != EA)) |-> (bus_rdata == 8'h00)); // R12
endmodule

bind ife_unit ife_unit_chk #(
  .ADDR_W(ADDR_W), .FLAG_OFS(FLAG_OFS), .EN_OFS(EN_OFS),
  .T1_BIT(T1_BIT), .SR_BIT(SR_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .t1_expire(t1_expire), .sr_done(sr_done), .sr_read(sr_read),
  .ext_lvl(ext_lvl), .flags_q(flags_q), .en_q(en_q), .irq(irq)
);

// File: tb/ife_unit_test.sv
`timescale 1ns/1ps
module ife_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] FLAG_A = 4'd13;
  localparam logic [3:0] EN_A   = 4'd14;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       t1_expire = 0, t2_expire = 0, sr_done = 0;
  logic       t1_lo_read = 0, t2_lo_read = 0, sr_read = 0;
  logic [3:0] ext_lvl = '0;
  logic       irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ife_unit uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .t1_expire(t1_expire), .t2_expire(t2_expire), .sr_done(sr_done),
    .t1_lo_read(t1_lo_read), .t2_lo_read(t2_lo_read), .sr_read(sr_read),
    .ext_lvl(ext_lvl), .irq(irq)
  );

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1; #1;
    d = bus_rdata;
    bus_rd = 1'b0; #1;
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic expect_reg(input string req, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd_reg(a, d);
    check8(req, d, exp);
  endtask

  task automatic expect_irq(input string req, input logic exp);
    check8(req, {7'd0, irq}, {7'd0, exp});
  endtask

  task automatic t_reset();
    expect_reg("R1 flags after reset", FLAG_A, 8'h00);
    expect_reg("R1/R6 enables after reset", EN_A, 8'h80);
    expect_irq("R1 irq after reset", 1'b0);
  endtask

  task automatic t_pulses();
    t1_expire = 1; tick(); t1_expire = 0;
    expect_reg("R9 timer1 pulse sets bit 6", FLAG_A, 8'h40);
    expect_irq("R2 pending but disabled", 1'b0);
    wr_reg(EN_A, 8'hC0);
    expect_reg("R4/R6 enable bit 6", EN_A, 8'hC0);
    expect_reg("R7 summary bit", FLAG_A, 8'hC0);
    expect_irq("R2 pending and enabled", 1'b1);
    t2_expire = 1; sr_done = 1; tick(); t2_expire = 0; sr_done = 0;
    expect_reg("R9 timer2 and shift pulses", FLAG_A, 8'hE4);
  endtask

  task automatic t_w1c();
    wr_reg(FLAG_A, 8'h20);
    expect_reg("R3 clear bit 5 only", FLAG_A, 8'hC4);
    wr_reg(FLAG_A, 8'h00);
    expect_reg("R3 zero write no change", FLAG_A, 8'hC4);
    wr_reg(FLAG_A, 8'h40);
    expect_reg("R3/R7 clear bit 6, bit 2 disabled", FLAG_A, 8'h04);
    expect_irq("R2 only disabled flag left", 1'b0);
  endtask

  task automatic t_strobes();
    t1_expire = 1; t2_expire = 1; tick(); t1_expire = 0; t2_expire = 0;
    expect_reg("R9 setup", FLAG_A, 8'hE4);
    sr_read = 1; tick(); sr_read = 0;
    expect_reg("R10 shift read clears bit 2", FLAG_A, 8'hE0);
    t1_lo_read = 1; tick(); t1_lo_read = 0;
    expect_reg("R10 timer1 read clears bit 6", FLAG_A, 8'h20);
    t2_lo_read = 1; tick(); t2_lo_read = 0;
    expect_reg("R10 timer2 read clears bit 5", FLAG_A, 8'h00);
  endtask

  task automatic t_enables();
    wr_reg(EN_A, 8'h85);
    expect_reg("R4 set bits 0 and 2", EN_A, 8'hC5);
    wr_reg(EN_A, 8'h01);
    expect_reg("R5 clear bit 0", EN_A, 8'hC4);
    wr_reg(EN_A, 8'h7F);
    expect_reg("R5 clear all", EN_A, 8'h80);
  endtask

  task automatic t_levels();
    ext_lvl = 4'b1010; tick();
    expect_reg("R8 levels map to bits 1 and 4", FLAG_A, 8'h12);
    expect_irq("R2 levels disabled", 1'b0);
    wr_reg(EN_A, 8'h90);
    expect_reg("R7/R8 level enabled", FLAG_A, 8'h92);
    expect_irq("R2 level enabled", 1'b1);
    wr_reg(FLAG_A, 8'h12);
    expect_reg("R8 high level beats clear", FLAG_A, 8'h92);
    ext_lvl = 4'b0000; tick();
    expect_reg("R8 low level clears", FLAG_A, 8'h00);
    expect_irq("R2 level dropped", 1'b0);
    wr_reg(EN_A, 8'h7F);
  endtask

  task automatic t_set_wins();
    t1_expire = 1; t1_lo_read = 1; tick(); t1_expire = 0; t1_lo_read = 0;
    expect_reg("R11 pulse beats read strobe", FLAG_A, 8'h40);
    sr_done = 1; wr_reg(FLAG_A, 8'h44); sr_done = 0;
    expect_reg("R11 pulse beats write clear", FLAG_A, 8'h04);
    wr_reg(FLAG_A, 8'h7F);
    expect_reg("R3 cleanup", FLAG_A, 8'h00);
  endtask

  task automatic t_other();
    t2_expire = 1; tick(); t2_expire = 0;
    wr_reg(4'd5, 8'hFF);
    wr_reg(4'd12, 8'h7F);
    wr_reg(4'd15, 8'hFF);
    expect_reg("R12 enables untouched", EN_A, 8'h80);
    expect_reg("R12 flags untouched", FLAG_A, 8'h20);
    expect_reg("R12 other offset reads zero", 4'd3, 8'h00);
    bus_addr = EN_A; #1;
    check8("R12 no read strobe reads zero", bus_rdata, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    t_reset();
    t_pulses();
    t_w1c();
    t_strobes();
    t_enables();
    t_levels();
    t_set_wins();
    t_other();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule